// File: doc/BRIEF.md
# Nametable address mirroring controller

The controller sits on the picture bus of a tile-based video processor and translates the 4 KB nametable window into accesses to a smaller physical video RAM. It watches the 14-bit picture-bus address and the read and write strobes. From them it produces a chip-select for the 2 KB internal nametable RAM, a chip-select for an optional 2 KB on-cartridge RAM, the RAM's upper address bit (bit 10) and the ten low address bits. The translation is purely combinational, so it adds no cycle of latency to a lookup.

The controller offers seven layouts: horizontal, vertical, single-screen low, single-screen high, diagonal (XOR), L-shaped (OR) and four-screen. The layout in force is picked by a fixed priority. A header four-screen setting wins first. If it is clear and mapper control is enabled, a 3-bit mode register written by a host bus decides. Otherwise a header horizontal/vertical bit decides. The mode register resets to the layout the header bit selects. A host write takes effect on the cycle after the write.

Top module: `ntmirror_ctrl`

## Requirements
- R1: A chip-select (`int_cs` or `ext_cs`) is asserted only while `ppu_rd` or `ppu_wr` is high, `ppu_addr[13]` is 1 and `ppu_addr` is below 14'h3F00. The two selects are never high together.
- R2: Mode code 3'd0 (horizontal) drives `ram_a10` = `ppu_addr[11]` and selects only the internal RAM. Code 3'd7 behaves the same way.
- R3: Mode code 3'd1 (vertical) drives `ram_a10` = `ppu_addr[10]` and selects only the internal RAM.
- R4: Mode codes 3'd2 and 3'd3 (single-screen) drive `ram_a10` to the constant 0 and 1 respectively, whatever the address.
- R5: Mode code 3'd4 (diagonal) drives `ram_a10` = A11 XOR A10. Mode code 3'd5 (L-shaped) drives `ram_a10` = A11 OR A10.
- R6: Mode code 3'd6 (four-screen) drives `ram_a10` = A10. It selects the external RAM when A11 = 1 and the internal RAM when A11 = 0.
- R7: When `hdr_four` is high, four-screen translation applies regardless of `map_ctl`, `hdr_vert` and the mode register.
- R8: With `hdr_four` low and `map_ctl` high, the mode register decides the layout and `hdr_vert` has no effect.
- R9: With `hdr_four` and `map_ctl` low, `hdr_vert` = 1 gives vertical and `hdr_vert` = 0 gives horizontal.
- R10: Reset loads the mode register with 3'd1 when `hdr_vert` = 1 and with 3'd0 otherwise.
- R11: A write (`host_we` high at a rising edge) loads `host_wdata` into the mode register. It takes effect from the next cycle, and outputs follow the address in the same cycle.
- R12: `ram_a` equals `ppu_addr[9:0]`, so an address in 14'h3000-14'h3EFF translates exactly like the one 14'h1000 lower.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_vert | input | 1 | Static header layout bit: 1 vertical, 0 horizontal |
| hdr_four | input | 1 | Static header four-screen enable |
| map_ctl | input | 1 | Mode register controls the layout |
| host_we | input | 1 | Mode register write strobe |
| host_wdata | input | 3 | Mode code to write |
| ppu_addr | input | 14 | Picture-bus address |
| ppu_rd | input | 1 | Picture-bus read strobe |
| ppu_wr | input | 1 | Picture-bus write strobe |
| int_cs | output | 1 | Internal 2 KB RAM select |
| ext_cs | output | 1 | External 2 KB RAM select |
| ram_a10 | output | 1 | RAM address bit 10 |
| ram_a | output | 10 | RAM address bits 9:0 |

## Verification
The hardest situation to reach is a conflict between layout sources. One example is a mode register holding a non-default code while the header four-screen bit or the header H/V bit points elsewhere. The other is the register's reset value seen through mapper control before any write. The bench reaches these cases by holding the header inputs at chosen values across separate resets. It writes codes through the host strobe and only then toggles `map_ctl` and `hdr_four`. It then sweeps all four tables and the folded window for each combination.

// File: rtl/ntmirror_ctrl.sv
module ntmirror_ctrl #(
  parameter int AW = 14,
  parameter int MW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hdr_vert,
  input  logic          hdr_four,
  input  logic          map_ctl,
  input  logic          host_we,
  input  logic [MW-1:0] host_wdata,
  input  logic [AW-1:0] ppu_addr,
  input  logic          ppu_rd,
  input  logic          ppu_wr,
  output logic          int_cs,
  output logic          ext_cs,
  output logic          ram_a10,
  output logic [9:0]    ram_a
);

  localparam logic [MW-1:0] M_HORZ = MW'(0);
  localparam logic [MW-1:0] M_VERT = MW'(1);
  localparam logic [MW-1:0] M_LOW  = MW'(2);
  localparam logic [MW-1:0] M_HIGH = MW'(3);
  localparam logic [MW-1:0] M_DIAG = MW'(4);
  localparam logic [MW-1:0] M_ELL  = MW'(5);
  localparam logic [MW-1:0] M_FOUR = MW'(6);

  logic [MW-1:0] mode_q;
  logic [MW-1:0] mode_eff;
  logic          a11, a10, in_win, four;

  always_ff @(posedge clk) begin
    if (!rst_n)
      mode_q <= hdr_vert ? M_VERT : M_HORZ;
    else if (host_we)
      mode_q <= host_wdata;
  end

  always_comb begin
    if (hdr_four)      mode_eff = M_FOUR;
    else if (map_ctl)  mode_eff = mode_q;
    else if (hdr_vert) mode_eff = M_VERT;
    else               mode_eff = M_HORZ;
  end

  assign a11    = ppu_addr[11];
  assign a10    = ppu_addr[10];
  assign in_win = ppu_addr[13] && (ppu_addr[12:8] != 5'h1F) && (ppu_rd || ppu_wr);
  assign four   = (mode_eff == M_FOUR);

  always_comb begin
    unique case (mode_eff)
      M_VERT:  ram_a10 = a10;
      M_LOW:   ram_a10 = 1'b0;
      M_HIGH:  ram_a10 = 1'b1;
      M_DIAG:  ram_a10 = a11 ^ a10;
      M_ELL:   ram_a10 = a11 | a10;
      M_FOUR:  ram_a10 = a10;
      default: ram_a10 = a11;
    endcase
  end

  assign int_cs = in_win && !(four && a11);
  assign ext_cs = in_win && four && a11;
  assign ram_a  = ppu_addr[9:0];

  AST_CS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(int_cs && ext_cs)); // R1
  AST_NO_CS_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ppu_addr[13] || ppu_addr[12:8] == 5'h1F || !(ppu_rd || ppu_wr)) |-> !(int_cs || ext_cs)); // R1
  AST_FOUR_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_four && (int_cs || ext_cs)) |-> (ram_a10 == ppu_addr[10] && ext_cs == ppu_addr[11])); // R7
  AST_HEADER_HV: assert property (@(posedge clk) disable iff (!rst_n)
    (!hdr_four && !map_ctl) |-> (ram_a10 == (hdr_vert ? ppu_addr[10] : ppu_addr[11]) && !ext_cs)); // R9
  AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    host_we |=> (mode_q == $past(host_wdata))); // R11
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_we && !$past(!rst_n)) |=> $stable(mode_q)); // R11
  AST_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    ram_a == ppu_addr[9:0]); // R12

endmodule

// File: tb/ntmirror_ctrl_test.sv
`timescale 1ns/1ps
module ntmirror_ctrl_test;
  logic clk = 0, rst_n = 0;
  logic hdr_vert = 0, hdr_four = 0, map_ctl = 0, host_we = 0;
  logic [2:0] host_wdata = 0;
  logic [13:0] ppu_addr = 0;
  logic ppu_rd = 0, ppu_wr = 0;
  logic int_cs, ext_cs, ram_a10;
  logic [9:0] ram_a;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ntmirror_ctrl uut (.*);

  // expected {int_cs, ext_cs, ram_a10} for layout code m
  function automatic logic [2:0] model(input logic [2:0] m, input logic [13:0] a, input logic acc);
    logic hit, x11, x10, b;
    hit = acc && a[13] && (a < 14'h3F00);
    x11 = a[11]; x10 = a[10];
    case (m)
      3'd1: b = x10;
      3'd2: b = 1'b0;
      3'd3: b = 1'b1;
      3'd4: b = x11 ^ x10;
      3'd5: b = x11 | x10;
      3'd6: b = x10;
      default: b = x11;
    endcase
    if (m == 3'd6) return {hit && !x11, hit && x11, b};
    return {hit, 1'b0, b};
  endfunction

  task automatic probe(input string req, input logic [2:0] m, input logic [13:0] a,
                       input logic rd, input logic wr);
    logic [2:0] exp, got;
    @(negedge clk);
    ppu_addr = a; ppu_rd = rd; ppu_wr = wr;
    #1;
    exp = model(m, a, rd | wr);
    got = {int_cs, ext_cs, ram_a10};
    checks++;
    if ((rd | wr) && (int_cs | ext_cs) && got != exp || !(int_cs | ext_cs) && got[2:1] != exp[2:1]
        || (int_cs | ext_cs) && got != exp || ram_a != a[9:0]) begin
      fails++;
      $display("FAIL %s addr=%h got cs/a10=%b a=%h expected %b a=%h", req, a, got, ram_a, exp, a[9:0]);
    end
  endtask

  task automatic sweep(input string req, input logic [2:0] m);
    for (int t = 0; t < 4; t++) begin
      probe(req, m, 14'h2000 + 14'(t * 14'h400) + 14'h0A5, 1, 0);
      probe(req, m, 14'h3000 + 14'(t * 14'h300) + 14'h05A, 0, 1);
    end
  endtask

  task automatic do_reset(input logic v);
    @(negedge clk);
    hdr_vert = v; rst_n = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
  endtask

  task automatic wr_mode(input logic [2:0] m);
    @(negedge clk);
    host_we = 1; host_wdata = m;
    @(negedge clk);
    host_we = 0; host_wdata = ~m;
  endtask

  task automatic t_reset_state;
    do_reset(1); map_ctl = 1; hdr_four = 0;
    sweep("R10 reset vertical", 3'd1);
    do_reset(0);
    sweep("R10 reset horizontal", 3'd0);
  endtask

  task automatic t_window;
    map_ctl = 0; hdr_four = 0; hdr_vert = 0;
    probe("R1 idle strobe", 3'd0, 14'h2400, 0, 0);
    probe("R1 below window", 3'd0, 14'h1C00, 1, 0);
    probe("R1 palette area", 3'd0, 14'h3F00, 1, 0);
    probe("R1 top of fold", 3'd0, 14'h3EFF, 0, 1);
    probe("R1 start window", 3'd0, 14'h2000, 1, 0);
  endtask

  task automatic t_modes;
    map_ctl = 1; hdr_four = 0;
    for (int m = 0; m < 8; m++) begin
      wr_mode(3'(m));
      case (m)
        0, 7: sweep("R2 horizontal", 3'(m));
        1: sweep("R3 vertical", 3'(m));
        2, 3: sweep("R4 single", 3'(m));
        4, 5: sweep("R5 diag/ell", 3'(m));
        default: sweep("R6 four-screen reg", 3'(m));
      endcase
    end
  endtask

  task automatic t_latency;
    map_ctl = 1; hdr_four = 0;
    wr_mode(3'd2);
    @(negedge clk);
    ppu_addr = 14'h2C00; ppu_rd = 1; host_we = 1; host_wdata = 3'd3;
    #1; checks++;
    if (ram_a10 !== 1'b0) begin fails++; $display("FAIL R11 before edge a10=%b expected 0", ram_a10); end
    @(negedge clk); host_we = 0;
    #1; checks++;
    if (ram_a10 !== 1'b1) begin fails++; $display("FAIL R11 after edge a10=%b expected 1", ram_a10); end
  endtask

  task automatic t_priority;
    map_ctl = 1; wr_mode(3'd2);
    hdr_vert = 1; hdr_four = 0;
    sweep("R8 header ignored v=1", 3'd2);
    hdr_vert = 0;
    sweep("R8 header ignored v=0", 3'd2);
    hdr_four = 1;
    sweep("R7 four overrides reg", 3'd6);
    map_ctl = 0; hdr_vert = 1;
    sweep("R7 four overrides header", 3'd6);
    hdr_four = 0;
    sweep("R9 header vertical", 3'd1);
    hdr_vert = 0;
    sweep("R9 header horizontal", 3'd0);
    map_ctl = 1;
    sweep("R8 register restored", 3'd2);
  endtask

  task automatic t_fold;
    map_ctl = 1; hdr_four = 0; wr_mode(3'd4);
    for (int k = 0; k < 15; k++) begin
      probe("R12 folded", 3'd4, 14'h3000 + 14'(k * 14'h100) + 14'(k), 1, 0);
      probe("R12 base", 3'd4, 14'h2000 + 14'(k * 14'h100) + 14'(k), 1, 0);
    end
  endtask

  initial begin
    t_reset_state();
    t_window();
    t_modes();
    t_latency();
    t_priority();
    t_fold();
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin @(posedge clk); cyc++; end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired got running expected finished");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule